// File: doc/BRIEF.md
# Chainable fall-through FIFO

A FIFO built from a row of identical stages, each of which shows its oldest word at its outputs without being asked. Each stage talks to its neighbours only through active-low ready flags. A stage pulls its output-ready flag low while a valid word sits on its outputs. It pulls its input-ready flag low while it has room for another word. The chain links the output-ready flag of one stage to the write enable of the next stage. It also links the input-ready flag of the next stage to the read enable of the previous stage. The data buses connect straight through, so words move toward the tail and free slots move toward the head with no added logic.

All stages share one clock. Inside each stage the read side sees the write pointer, and the write side sees the read pointer, only after a fixed number of register delays. This gives every stage a fixed transfer latency. A new word reaches the chain's output after a known number of cycles, and a slot freed at the tail reaches the head after a known number of cycles. Once the pipeline has filled, the chain moves one word per cycle. Each stage holds 2**AW + 1 words: 2**AW in its RAM and one in its output register. The depth of the chain is the sum over its stages.

Top module: `cfwft_chain`

## Requirements
- R1: While rst_ni is low and after it rises, out_rdy_no is 1, in_rdy_no is 0 and rd_data_o is 0 in every stage.
- R2: A word written into an empty chain appears on rd_data_o without any read, and out_rdy_no stays 0 with that word held stable until it is read.
- R3: With default delays, a word accepted at clock edge t into an empty chain of N stages drives out_rdy_no low after edge t + 4*(N-1) + 3.
- R4: Words leave in the order they were accepted, and no word is lost or duplicated.
- R5: With no reads, the chain accepts exactly N*(2**AW+1) words and then holds in_rdy_no at 1. A write (wr_en_ni = 0) presented while in_rdy_no is 1 is dropped.
- R6: After a single read at edge t from a full chain, in_rdy_no first returns to 0 after edge t + 3*(N-1) + 2.
- R7: A read takes place only when rd_en_ni = 0, rd_cs_ni = 0 and out_rdy_no = 0. With rd_cs_ni = 1 the output word and flag stay unchanged.
- R8: A read presented while out_rdy_no = 1 is ignored. A word written later still comes out intact and on time.
- R9: A back-to-back burst written into an empty chain while the tail is read whenever ready leaves the chain one word per cycle. Word i appears exactly i cycles after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared transfer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | WIDTH | Data into the head stage |
| wr_en_ni | input | 1 | Write request, active low |
| in_rdy_no | output | 1 | Head stage has room, active low |
| rd_data_o | output | WIDTH | Oldest word at the tail stage |
| rd_en_ni | input | 1 | Read request, active low |
| rd_cs_ni | input | 1 | Read select, active low |
| out_rdy_no | output | 1 | Tail word valid, active low |

## Verification
The bench measures the ripple latency of a single word and the return latency of a single freed slot edge by edge. A stage with one pointer delay too many or too few therefore shows up as a count off by N-1 or more. It fills the chain to its exact capacity and offers extra words while the chain is full. A full test that is off by one would then accept one extra word or stop one short, and the drain count would show it. Reads with the select deasserted, and reads against an empty chain, must leave the output untouched. A design that ignored the select, or advanced its read pointer with no data, would skip or corrupt words. A continuous burst must come out with no gaps and in order, which catches a stage that stalls its output register for one cycle after each transfer.

// File: rtl/cfwft_pkg.sv
package cfwft_pkg;
  localparam int unsigned DEF_WIDTH  = 72;
  localparam int unsigned DEF_AW     = 3;
  localparam int unsigned DEF_STAGES = 3;
  // pointer visibility delays; both must be >= 1
  localparam int unsigned DEF_FWD    = 2;
  localparam int unsigned DEF_BWD    = 2;
endpackage

// File: rtl/cfwft_ram.sv
module cfwft_ram #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cfwft_dly.sv
module cfwft_dly #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  timeunit 1ns; timeprecision 1ps;

  generate
    if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_pipe
      logic [W-1:0] pipe_q [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[i] <= '0;
          else if (i == 0) pipe_q[i] <= d_i;
          else pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
        end
      end
      assign q_o = pipe_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/cfwft_stage.sv
module cfwft_stage #(
  parameter int unsigned W   = cfwft_pkg::DEF_WIDTH,
  parameter int unsigned AW  = cfwft_pkg::DEF_AW,
  parameter int unsigned FWD = cfwft_pkg::DEF_FWD,
  parameter int unsigned BWD = cfwft_pkg::DEF_BWD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         wen_ni,
  output logic         ir_no,
  output logic [W-1:0] dout_o,
  input  logic         ren_ni,
  input  logic         rcs_ni,
  output logic         or_no
);
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned PW   = AW + 1;
  localparam int unsigned MEMD = 1 << AW;

  logic [PW-1:0] wr_ptr, rd_ptr, wr_ptr_rv, rd_ptr_wv;
  logic [PW-1:0] cnt_rv, cnt_wv;
  logic [W-1:0]  ram_q;
  logic          wr_fire, rd_fire, load;

  // write side
  assign cnt_wv  = wr_ptr - rd_ptr_wv;
  assign ir_no   = (cnt_wv == PW'(MEMD));
  assign wr_fire = !wen_ni && !ir_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr <= '0;
    else if (wr_fire) wr_ptr <= wr_ptr + PW'(1);
  end

  cfwft_ram #(.W(W), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .waddr_i (wr_ptr[AW-1:0]),
    .wdata_i (din_i),
    .raddr_i (rd_ptr[AW-1:0]),
    .rdata_o (ram_q)
  );

  // pointer views across the stage
  cfwft_dly #(.W(PW), .DEPTH(FWD)) u_fwd (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (wr_ptr), .q_o (wr_ptr_rv)
  );
  cfwft_dly #(.W(PW), .DEPTH(BWD)) u_bwd (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (rd_ptr), .q_o (rd_ptr_wv)
  );

  // read side: output register falls through
  assign cnt_rv  = wr_ptr_rv - rd_ptr;
  assign rd_fire = !ren_ni && !rcs_ni && !or_no;
  assign load    = (cnt_rv != '0) && (or_no || rd_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      dout_o <= '0;
      or_no  <= 1'b1;
    end else if (load) begin
      rd_ptr <= rd_ptr + PW'(1);
      dout_o <= ram_q;
      or_no  <= 1'b0;
    end else if (rd_fire) begin
      or_no  <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr - rd_ptr) <= PW'(MEMD)); // R5
  AST_FULL_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wen_ni && ir_no) |=> $stable(wr_ptr)); // R5
  AST_LOAD_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> ((wr_ptr - rd_ptr) != '0)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!or_no && !rd_fire) |=> (!or_no && $stable(dout_o))); // R2
  AST_RCS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcs_ni && !or_no) |=> !or_no); // R7
endmodule

// File: rtl/cfwft_chain.sv
module cfwft_chain #(
  parameter int unsigned WIDTH  = cfwft_pkg::DEF_WIDTH,
  parameter int unsigned AW     = cfwft_pkg::DEF_AW,
  parameter int unsigned STAGES = cfwft_pkg::DEF_STAGES,
  parameter int unsigned FWD    = cfwft_pkg::DEF_FWD,
  parameter int unsigned BWD    = cfwft_pkg::DEF_BWD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             wr_en_ni,
  output logic             in_rdy_no,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             rd_en_ni,
  input  logic             rd_cs_ni,
  output logic             out_rdy_no
);
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] st_din  [STAGES];
  logic [WIDTH-1:0] st_dout [STAGES];
  logic             st_wen  [STAGES];
  logic             st_ir   [STAGES];
  logic             st_ren  [STAGES];
  logic             st_rcs  [STAGES];
  logic             st_or   [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign st_din[i] = wr_data_i;
        assign st_wen[i] = wr_en_ni;
      end else begin : g_link_in
        assign st_din[i] = st_dout[i-1];
        assign st_wen[i] = st_or[i-1];
      end
      if (i == LAST) begin : g_tail
        assign st_ren[i] = rd_en_ni;
        assign st_rcs[i] = rd_cs_ni;
      end else begin : g_link_out
        assign st_ren[i] = st_ir[i+1];
        assign st_rcs[i] = 1'b0;
      end

      cfwft_stage #(.W(WIDTH), .AW(AW), .FWD(FWD), .BWD(BWD)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (st_din[i]),
        .wen_ni (st_wen[i]),
        .ir_no  (st_ir[i]),
        .dout_o (st_dout[i]),
        .ren_ni (st_ren[i]),
        .rcs_ni (st_rcs[i]),
        .or_no  (st_or[i])
      );
    end
  endgenerate

  assign in_rdy_no  = st_ir[0];
  assign rd_data_o  = st_dout[LAST];
  assign out_rdy_no = st_or[LAST];

  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(out_rdy_no) && out_rdy_no) |-> $stable(rd_data_o)); // R1
endmodule

// File: tb/sim_cfwft_chain.sv
module sim_cfwft_chain;
  timeunit 1ns; timeprecision 1ps;
  localparam int W    = 16;
  localparam int AW   = 3;
  localparam int N    = 3;
  localparam int CAP  = N * ((1 << AW) + 1);
  localparam int L_FW = 4 * (N - 1) + 3;
  localparam int L_BU = 3 * (N - 1) + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         wen_n = 1'b1;
  logic         ir_n;
  logic [W-1:0] rdata;
  logic         ren_n = 1'b1;
  logic         rcs_n = 1'b1;
  logic         or_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  logic [W-1:0] model[$];

  always #2 clk = ~clk; // 4 ns period

  cfwft_chain #(.WIDTH(W), .AW(AW), .STAGES(N)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .wr_data_i (wdata), .wr_en_ni (wen_n),
    .in_rdy_no (ir_n), .rd_data_o (rdata), .rd_en_ni (ren_n),
    .rd_cs_ni (rcs_n), .out_rdy_no (or_n)
  );

  task automatic tick();
    @(posedge clk); #1;
    cyc++;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(or_n == 1'b1, "R1 out_rdy", int'(or_n), 1);
    chk(ir_n == 1'b0, "R1 in_rdy", int'(ir_n), 0);
    chk(rdata == '0, "R1 data", int'(rdata), 0);
    rst_n = 1'b1;
    tick();
    chk(or_n == 1'b1 && ir_n == 1'b0 && rdata == '0, "R1 after release",
        int'({or_n, ir_n}), 2);
  endtask

  task automatic pop_one(input string req);
    logic [W-1:0] exp;
    exp = model.pop_front();
    chk(rdata == exp, req, int'(rdata), int'(exp));
    ren_n = 1'b0; rcs_n = 1'b0;
    tick();
    ren_n = 1'b1; rcs_n = 1'b1;
  endtask

  task automatic wait_word(output int k);
    k = 0;
    while (or_n && k < 200) begin
      tick(); k++;
    end
  endtask

  task automatic t_first_word();
    int k;
    wdata = 16'hA5C3; wen_n = 1'b0;
    tick();
    wen_n = 1'b1; model.push_back(16'hA5C3);
    wait_word(k);
    chk(k == L_FW, "R3 first-word latency", k, L_FW);
    chk(rdata == 16'hA5C3, "R2 fall-through data", int'(rdata), 16'hA5C3);
    for (int i = 0; i < 4; i++) tick();
    chk(or_n == 1'b0 && rdata == 16'hA5C3, "R2 held without read", int'(rdata), 16'hA5C3);
  endtask

  task automatic t_rcs_block();
    ren_n = 1'b0; rcs_n = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    ren_n = 1'b1;
    chk(or_n == 1'b0, "R7 flag with select off", int'(or_n), 0);
    chk(rdata == 16'hA5C3, "R7 data with select off", int'(rdata), 16'hA5C3);
    pop_one("R7 selected read");
    chk(or_n == 1'b1, "R7 empty after read", int'(or_n), 1);
  endtask

  task automatic t_empty_read();
    int k;
    ren_n = 1'b0; rcs_n = 1'b0;
    for (int i = 0; i < 6; i++) tick();
    chk(or_n == 1'b1, "R8 empty read ignored", int'(or_n), 1);
    ren_n = 1'b1; rcs_n = 1'b1;
    wdata = 16'h1234; wen_n = 1'b0;
    tick();
    wen_n = 1'b1; model.push_back(16'h1234);
    wait_word(k);
    chk(k == L_FW, "R8 latency after empty read", k, L_FW);
    pop_one("R8 data after empty read");
  endtask

  task automatic t_burst();
    int wr_edge[10];
    int nw = 0, nr = 0, guard = 0;
    logic [W-1:0] exp;
    while (nr < 10 && guard < 200) begin
      if (nw < 10 && !ir_n) begin
        wdata = W'(16'h3000 + nw); wen_n = 1'b0;
      end else wen_n = 1'b1;
      tick(); guard++;
      if (!wen_n) begin
        wr_edge[nw] = cyc; model.push_back(wdata); nw++;
      end
      ren_n = 1'b1; rcs_n = 1'b1;
      if (!or_n) begin
        exp = model.pop_front();
        chk(rdata == exp, "R4 burst order", int'(rdata), int'(exp));
        chk(cyc == wr_edge[nr] + L_FW, "R9 burst timing", cyc, wr_edge[nr] + L_FW);
        nr++;
        ren_n = 1'b0; rcs_n = 1'b0;
      end
    end
    wen_n = 1'b1;
    tick();
    ren_n = 1'b1; rcs_n = 1'b1;
    chk(nr == 10, "R9 burst count", nr, 10);
  endtask

  task automatic t_fill_bubble();
    int acc = 0, guard = 0, k, got = 0, idle = 0;
    bit was_free;
    while (acc < CAP && guard < 1000) begin
      was_free = !ir_n;
      if (was_free) begin
        wdata = W'(16'h5000 + acc); wen_n = 1'b0;
      end
      tick(); guard++;
      if (was_free) begin
        model.push_back(wdata); acc++;
      end
      wen_n = 1'b1;
    end
    for (int i = 0; i < 60; i++) tick();
    chk(ir_n == 1'b1, "R5 full flag", int'(ir_n), 1);
    wdata = 16'hDEAD; wen_n = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    wen_n = 1'b1;
    chk(ir_n == 1'b1, "R5 still full", int'(ir_n), 1);
    pop_one("R6 read from full");
    k = 0;
    while (ir_n && k < 200) begin
      tick(); k++;
    end
    chk(k == L_BU, "R6 free-slot latency", k, L_BU);
    got = 1;
    while (idle < 40) begin
      if (!or_n) begin
        pop_one("R4 drain order");
        got++; idle = 0;
      end else begin
        tick(); idle++;
      end
    end
    chk(got == CAP, "R5 capacity, full write dropped", got, CAP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #9;
    t_reset();
    t_first_word();
    t_rcs_block();
    t_empty_read();
    t_burst();
    t_fill_bubble();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule